// File: doc/BRIEF.md
# PWM Dead-Band and Trip Guard

This block sits between a PWM generator and the output drivers. For each channel it holds back the active-going (rising) edge of the raw PWM signal by a programmable number of delay units. The falling edge is not held back. Complementary outputs driven through two channels therefore never overlap. Each delay unit is one prescaler period of four system clocks. A pulse whose width is no longer than the programmed delay never reaches the output.

A trip flag forces every output to a fixed safe level. An external trip event sets the flag, and so does a software write. Two recovery modes exist. In automatic mode the flag drops as soon as no event is present. In sticky mode the flag stays set until software clears it. When the flag drops while the raw input is high, the channel treats that input as a fresh active edge and the full delay applies again.

A small write port loads the configuration word and the trip flag. The configuration word holds the delay count and the restart mode. All outputs are registered.

Top module: `pwm_deadband_guard`

## Requirements
- R1: After reset `pwm_o` is all zero, `trip_o` is 0, the delay count is 0 and sticky mode is selected.
- R2: With delay count d > 0, when an edge first samples `pwm_i[c]` high (edge k), `pwm_o[c]` rises at edge k + 4·d. The pulse end is unchanged.
- R3: When an edge samples `pwm_i[c]` low and the trip flag is not set after that edge, `pwm_o[c]` is 0 after that same edge. Falling edges therefore have one cycle of latency and no added delay.
- R4: A raw pulse of W clocks with W ≤ 4·d produces no output pulse. A raw pulse with W > 4·d produces an output pulse of W − 4·d clocks.
- R5: With delay count 0, `pwm_o` equals `pwm_i` delayed by one clock.
- R6: An edge that samples `trip_i` high sets `trip_o`. While `trip_o` is 1, `pwm_o` equals SAFE_LVL (default all zero).
- R7: In automatic mode (config bit 7 = 1), `trip_o` clears at the first edge that samples `trip_i` low, unless a status write occurs at that edge.
- R8: In sticky mode (config bit 7 = 0), `trip_o` stays 1 until a status write with bit 0 = 0 occurs while `trip_i` is low. A status write cannot clear the flag while `trip_i` is high.
- R9: A status write (`wr_addr_i` = 1) with bit 0 = 1 sets `trip_o` at that edge, with the same effect on the outputs as a trip event. In automatic mode, the flag clears again at the next edge that samples no event and no write.
- R10: When the trip flag clears while `pwm_i[c]` is high, the full 4·d delay is applied again, counted from the first edge after the flag drops.
- R11: A configuration write (`wr_addr_i` = 0) loads bits 6:0 as the delay count and bit 7 as the restart mode. A new count applies only to active edges sampled after the write edge. A delay already counting keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | N_CH | Raw PWM inputs |
| trip_i | input | 1 | External trip event, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the config word, 1 selects the trip status |
| wr_data_i | input | DLY_W+1 | Write data |
| pwm_o | output | N_CH | Shaped PWM outputs |
| trip_o | output | 1 | Trip flag |

## Verification
Two functions can act in the same cycle. A trip can begin or end while a channel is counting out its delay. A software status write can also land on the same edge as a trip event or an automatic clear. Directed sequences place trip pulses and status writes in the middle of delayed pulses. They also place a status write on the edge where the event ends. The random phase overlaps short trip pulses, configuration writes and raw toggling on both channels. A per-cycle reference model in the bench computes the flag first and then the per-channel run lengths. Every cycle is judged against that model. A wrong priority or a missed delay restart shows up as an output mismatch.

// File: rtl/pwm_dbg_pkg.sv
package pwm_dbg_pkg;
  typedef enum logic [1:0] {
    LANE_IDLE = 2'd0,
    LANE_WAIT = 2'd1,
    LANE_ON   = 2'd2
  } lane_st_e;

  localparam logic ADDR_CFG  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/pwm_dbg_cfg.sv
module pwm_dbg_cfg
  import pwm_dbg_pkg::*;
#(
  parameter int DLY_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [DLY_W:0]   wr_data_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             restart_o,
  output logic             st_wr_o,
  output logic             st_val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_o     <= '0;
      restart_o <= 1'b0;
    end else if (wr_en_i && wr_addr_i == ADDR_CFG) begin
      dly_o     <= wr_data_i[DLY_W-1:0];
      restart_o <= wr_data_i[DLY_W];
    end
  end

  assign st_wr_o  = wr_en_i && (wr_addr_i == ADDR_STAT);
  assign st_val_o = wr_data_i[0];
endmodule

// File: rtl/pwm_dbg_trip.sv
module pwm_dbg_trip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic restart_i,
  input  logic st_wr_i,
  input  logic st_val_i,
  output logic trip_d_o,
  output logic trip_q_o
);
  // event wins over software; software wins over auto-clear
  always_comb begin
    if (event_i)        trip_d_o = 1'b1;
    else if (st_wr_i)   trip_d_o = st_val_i;
    else if (restart_i) trip_d_o = 1'b0;
    else                trip_d_o = trip_q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trip_q_o <= 1'b0;
    else         trip_q_o <= trip_d_o;
  end
endmodule

// File: rtl/pwm_dbg_lane.sv
module pwm_dbg_lane
  import pwm_dbg_pkg::*;
#(
  parameter int   DLY_W = 7,
  parameter int   PRESC = 4,
  parameter logic SAFE  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             force_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             out_o
);
  localparam int SUB_W = (PRESC > 2) ? $clog2(PRESC) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PRESC - 1);
  localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);

  lane_st_e         st_q;
  logic [DLY_W-1:0] cnt_q;
  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LANE_IDLE;
      cnt_q <= '0;
      sub_q <= '0;
      out_o <= 1'b0;
    end else if (force_i) begin
      st_q  <= LANE_IDLE;
      out_o <= SAFE;
    end else if (!raw_i) begin
      st_q  <= LANE_IDLE;
      out_o <= 1'b0;
    end else begin
      unique case (st_q)
        LANE_IDLE: begin
          sub_q <= '0;
          cnt_q <= dly_i;
          if (dly_i == '0) begin
            st_q  <= LANE_ON;
            out_o <= 1'b1;
          end else begin
            st_q  <= LANE_WAIT;
            out_o <= 1'b0;
          end
        end
        LANE_WAIT: begin
          if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            if (cnt_q == CNT_ONE) begin
              st_q  <= LANE_ON;
              out_o <= 1'b1;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q - CNT_ONE;
            end
          end else begin
            sub_q <= sub_q + SUB_W'(1);
          end
        end
        default: begin
          st_q  <= LANE_ON;
          out_o <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwm_deadband_guard.sv
module pwm_deadband_guard
  import pwm_dbg_pkg::*;
#(
  parameter int              N_CH     = 2,
  parameter int              DLY_W    = 7,
  parameter int              PRESC    = 4,
  parameter logic [N_CH-1:0] SAFE_LVL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  pwm_i,
  input  logic             trip_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [DLY_W:0]   wr_data_i,
  output logic [N_CH-1:0]  pwm_o,
  output logic             trip_o
);
  logic [DLY_W-1:0] dly;
  logic             restart_en;
  logic             st_wr;
  logic             st_val;
  logic             trip_d;

  pwm_dbg_cfg #(.DLY_W(DLY_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .dly_o     (dly),
    .restart_o (restart_en),
    .st_wr_o   (st_wr),
    .st_val_o  (st_val)
  );

  pwm_dbg_trip i_trip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .event_i   (trip_i),
    .restart_i (restart_en),
    .st_wr_i   (st_wr),
    .st_val_i  (st_val),
    .trip_d_o  (trip_d),
    .trip_q_o  (trip_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    pwm_dbg_lane #(
      .DLY_W (DLY_W),
      .PRESC (PRESC),
      .SAFE  (SAFE_LVL[c])
    ) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (pwm_i[c]),
      .force_i (trip_d),
      .dly_i   (dly),
      .out_o   (pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm_dbg_chk.sv
module pwm_dbg_chk #(
  parameter int              N_CH     = 2,
  parameter int              DLY_W    = 7,
  parameter logic [N_CH-1:0] SAFE_LVL = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] pwm_i,
  input logic            trip_i,
  input logic            wr_en_i,
  input logic            wr_addr_i,
  input logic [DLY_W:0]  wr_data_i,
  input logic [N_CH-1:0] pwm_o,
  input logic            trip_o,
  input logic            restart_q
);
  logic st_wr;
  assign st_wr = wr_en_i && wr_addr_i;

  p_safe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> pwm_o == SAFE_LVL);
  p_event_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> trip_o);
  p_auto_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_q && !trip_i && !st_wr) |=> !trip_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !restart_q && !st_wr) |=> trip_o);
  p_swset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && wr_data_i[0]) |=> trip_o);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    p_rise_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwm_o[c] && !trip_o) |-> $past(pwm_i[c]));
    p_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwm_i[c] |=> (trip_o || !pwm_o[c]));
  end
endmodule

bind pwm_deadband_guard pwm_dbg_chk #(
  .N_CH(N_CH), .DLY_W(DLY_W), .SAFE_LVL(SAFE_LVL)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwm_i     (pwm_i),
  .trip_i    (trip_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .pwm_o     (pwm_o),
  .trip_o    (trip_o),
  .restart_q (restart_en)
);

// File: tb/test_pwm_deadband_guard.sv
module test_pwm_deadband_guard;
  localparam int N_CH  = 2;
  localparam int DLY_W = 7;
  localparam int PRESC = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_CH-1:0]  pwm_i = '0;
  logic             trip_i = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_addr = 1'b0;
  logic [DLY_W:0]   wr_data = '0;
  logic [N_CH-1:0]  pwm_o;
  logic             trip_o;

  always #2.5 clk = ~clk;

  pwm_deadband_guard #(.N_CH(N_CH), .DLY_W(DLY_W), .PRESC(PRESC)) i_pwm_deadband_guard (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm_i), .trip_i(trip_i),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pwm_o(pwm_o), .trip_o(trip_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";
  logic cmp_on = 1'b0;

  // reference model
  int              m_dly;
  logic            m_rst_en;
  logic            m_trip;
  int              run [N_CH];
  int              tgt [N_CH];
  logic [N_CH-1:0] m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dly = 0; m_rst_en = 1'b0; m_trip = 1'b0; m_out = '0;
      for (int c = 0; c < N_CH; c++) begin run[c] = 0; tgt[c] = 0; end
    end else begin
      logic nt;
      if (trip_i)                nt = 1'b1;
      else if (wr_en && wr_addr) nt = wr_data[0];
      else if (m_rst_en)         nt = 1'b0;
      else                       nt = m_trip;
      m_trip = nt;
      for (int c = 0; c < N_CH; c++) begin
        if (nt) begin
          run[c] = 0; m_out[c] = 1'b0;
        end else if (!pwm_i[c]) begin
          run[c] = 0; m_out[c] = 1'b0;
        end else begin
          if (run[c] == 0) tgt[c] = PRESC * m_dly;
          if (run[c] < 100000) run[c] = run[c] + 1;
          m_out[c] = (run[c] > tgt[c]);
        end
      end
      if (wr_en && !wr_addr) begin
        m_dly = int'(wr_data[DLY_W-1:0]);
        m_rst_en = wr_data[DLY_W];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      n_cmp++;
      if (pwm_o !== m_out || trip_o !== m_trip) begin
        n_bad++;
        $display("FAIL %s: pwm_o=%b exp=%b trip_o=%b exp=%b at %0t",
                 cur_tag, pwm_o, m_out, trip_o, m_trip, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [DLY_W:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int ch, input int w, input int gap);
    pwm_i[ch] = 1'b1; cyc(w);
    pwm_i[ch] = 1'b0; cyc(gap);
  endtask

  function automatic int tgt_edge_count(input int w, input int d);
    return (w > PRESC * d) ? w - PRESC * d : 0;
  endfunction

  bit done = 1'b0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    int hi_cnt;
    seed_dummy = $urandom(32'd1234);
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    cur_tag = "R1";
    chk("R1", pwm_o, 0);
    chk("R1", trip_o, 0);
    cmp_on = 1'b1;

    // R1 / R5: delay resets to zero -> one-cycle passthrough
    cur_tag = "R5";
    pwm_i[0] = 1'b1; cyc(1);
    chk("R5", pwm_o[0], 1);
    pwm_i[0] = 1'b0; cyc(1);
    chk("R3", pwm_o[0], 0);
    pulse(1, 3, 4);

    // R2: delay 3 -> rise 12 clocks late, width preserved minus delay
    cur_tag = "R11";
    wr(1'b0, 8'h03);
    cur_tag = "R2";
    hi_cnt = 0;
    pwm_i[0] = 1'b1;
    for (int i = 0; i < 20; i++) begin cyc(1); if (pwm_o[0]) hi_cnt++; end
    pwm_i[0] = 1'b0; cyc(1);
    if (pwm_o[0]) hi_cnt++;
    chk("R2", hi_cnt, tgt_edge_count(20, 3));
    cyc(4);

    // R4: width equal to delay suppressed, one more gives one clock
    cur_tag = "R4";
    hi_cnt = 0;
    pwm_i[0] = 1'b1;
    for (int i = 0; i < 12; i++) begin cyc(1); if (pwm_o[0]) hi_cnt++; end
    pwm_i[0] = 1'b0; cyc(1);
    if (pwm_o[0]) hi_cnt++;
    chk("R4", hi_cnt, 0);
    cyc(3);
    pulse(1, 13, 5);
    cur_tag = "R3";
    pulse(0, 30, 6);

    // R11: delay change mid-count keeps old count
    cur_tag = "R11";
    pwm_i[0] = 1'b1; cyc(2);
    wr(1'b0, 8'h01);
    cyc(14);
    pwm_i[0] = 1'b0; cyc(3);
    pulse(0, 9, 3);

    // R8: sticky mode
    cur_tag = "R8";
    pwm_i = 2'b11; cyc(10);
    trip_i = 1'b1; cyc(3);
    wr(1'b1, 8'h00);           // clear blocked while event present
    trip_i = 1'b0; cyc(6);
    chk("R8", trip_o, 1);
    wr(1'b1, 8'h00);
    chk("R8", trip_o, 0);
    cur_tag = "R10";
    cyc(8);

    // R7: automatic mode with restart while raw high
    cur_tag = "R7";
    wr(1'b0, 8'h82);
    cyc(10);
    trip_i = 1'b1; cyc(4);
    trip_i = 1'b0; cyc(1);
    chk("R7", trip_o, 0);
    cur_tag = "R10";
    cyc(6);
    chk("R10", pwm_o, 0);
    cyc(4);
    chk("R10", pwm_o, 2'b11);
    // event end collides with status write of 1
    cur_tag = "R7";
    trip_i = 1'b1; cyc(2);
    trip_i = 1'b0; wr(1'b1, 8'h01);
    cyc(3);

    // R9: software set in sticky mode
    cur_tag = "R9";
    wr(1'b0, 8'h02);
    cyc(10);
    wr(1'b1, 8'h01);
    chk("R9", trip_o, 1);
    chk("R9", pwm_o, 0);
    cyc(5);
    wr(1'b1, 8'h00);
    pwm_i = 2'b00; cyc(4);

    // random phase
    cur_tag = "R6";
    begin
      int left [N_CH];
      int trip_left = 0;
      for (int c = 0; c < N_CH; c++) left[c] = 1;
      for (int it = 0; it < 20000; it++) begin
        for (int c = 0; c < N_CH; c++) begin
          left[c]--;
          if (left[c] <= 0) begin
            pwm_i[c] = ~pwm_i[c];
            left[c] = 1 + ($urandom % 40);
          end
        end
        if (trip_left > 0) begin
          trip_left--;
          trip_i = (trip_left != 0);
        end else if (($urandom % 300) == 0) begin
          trip_left = 1 + ($urandom % 10);
          trip_i = 1'b1;
        end
        if (($urandom % 150) == 0) begin
          wr_en = 1'b1;
          wr_addr = $urandom % 2;
          wr_data = (($urandom % 8) == 0) ? 8'h7f : 8'($urandom % 8);
          wr_data[DLY_W] = $urandom % 2;
        end else begin
          wr_en = 1'b0;
        end
        cyc(1);
      end
      wr_en = 1'b0; trip_i = 1'b0;
      cyc(4);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule